// File: doc/BRIEF.md
# Two's-Complement to Packed Canonic Signed-Digit Encoder

The encoder takes a signed coefficient of WIDTH bits and recodes it into canonic signed-digit form. In that form every digit is -1, 0 or +1, no two neighbouring digits are both nonzero, and the number of nonzero digits is the minimum possible. It then packs the ternary result back into a plain binary word only one bit wider than the input. Each nonzero digit is followed by a zero digit. That zero's bit position holds the sign of the digit below it, so the packed word needs no separate sign lane.

The recoding runs as a carry chain from the least significant bit upward. The operand is first widened by a copy of its sign bit. At each position the cell looks at its own bit, the bit above and the incoming carry. It chooses a digit and passes a carry upward. The result is registered together with a count of nonzero digits, which a downstream multiplier can use to size its add/subtract schedule. A strobe marks which operands are converted. Between strobes the registered result holds.

Top module: `bcsd_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `code_out` and `nz_count` all become zero.
- R2: `out_valid` is high in exactly the cycle after a rising edge at which `in_valid` was high, and low otherwise.
- R3: On a rising edge with `in_valid` low, `code_out` and `nz_count` keep their previous values whatever `operand` does.
- R4: Reading `code_out` upward from bit 0, a set bit at an unclaimed position j marks a nonzero digit of weight 2^j and claims bit j+1 as its sign. The signed sum of these digits equals the signed value of the operand that was strobed.
- R5: The digit string has no two adjacent nonzero digits, so `code_out` equals the unique canonic (non-adjacent) form of the operand.
- R6: `nz_count` equals the number of nonzero digits in `code_out`, which is the minimum count for that value.
- R7: The sign bit in each pair is 0 for a +1 digit and 1 for a -1 digit. Pair (sign,mark) reads 01 for +1 and 11 for -1. Bit WIDTH is set only as the sign of a negative digit at position WIDTH-1, and the carry leaving the chain always equals the operand's sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Converts `operand` at this edge when high |
| operand | input | WIDTH | Signed two's-complement coefficient |
| out_valid | output | 1 | Result registers were loaded at the last edge |
| code_out | output | WIDTH+1 | Packed canonic signed-digit word |
| nz_count | output | $clog2(WIDTH/2+2) | Number of nonzero digits in `code_out` |

## Verification
The assertions take for granted that `operand` is stable and fully known around each edge at which `in_valid` is high. They also assume the value needs no digit above position WIDTH-1, which holds for any operand that fits WIDTH signed bits. The bench changes inputs only on falling edges and uses an 8-bit instance. That instance is driven exhaustively through all 256 operands, including both extremes of the signed range, so every input the assertions rely on is a legal coefficient. The bench compares each result against a canonic form it builds by repeated remainder-and-halve arithmetic rather than a carry chain.

// File: rtl/bcsd_pkg.sv
package bcsd_pkg;

    // Widest code word the checking helpers can walk.
    localparam int MAX_W = 64;

    // Digit values encoded as the packed (sign,mark) pair they produce.
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b11
    } digit_e;

    typedef struct packed {
        digit_e dig;
        logic   carry;
    } step_t;

    // One position of the non-adjacent recoding chain.
    function automatic step_t recode_step(input logic b, input logic b_up, input logic cin);
        step_t r;
        logic  mark;
        mark    = b ^ cin;
        r.carry = (b & b_up) | (b & cin) | (b_up & cin);
        if (!mark)
            r.dig = DIG_ZERO;
        else if (b_up)
            r.dig = DIG_NEG;
        else
            r.dig = DIG_POS;
        return r;
    endfunction

    // Value carried by a packed word of w+1 bits, read from the bottom up.
    function automatic longint packed_value(input logic [MAX_W:0] code, input int w);
        longint acc;
        logic   skip;
        acc  = 0;
        skip = 1'b0;
        for (int j = 0; j < MAX_W; j++) begin
            if (j < w) begin
                if (skip) begin
                    skip = 1'b0;
                end else if (code[j]) begin
                    if (code[j+1])
                        acc = acc - (longint'(1) <<< j);
                    else
                        acc = acc + (longint'(1) <<< j);
                    skip = 1'b1;
                end
            end
        end
        return acc;
    endfunction

    // Number of digit marks found by the same bottom-up walk.
    function automatic int packed_marks(input logic [MAX_W:0] code, input int w);
        int   n;
        logic skip;
        n    = 0;
        skip = 1'b0;
        for (int j = 0; j < MAX_W; j++) begin
            if (j < w) begin
                if (skip) begin
                    skip = 1'b0;
                end else if (code[j]) begin
                    n    = n + 1;
                    skip = 1'b1;
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/bcsd_recode_cell.sv
module bcsd_recode_cell
    import bcsd_pkg::*;
(
    input  logic   bit_here,
    input  logic   bit_above,
    input  logic   carry_in,
    output digit_e digit,
    output logic   carry_out
);

    step_t step;

    always_comb begin
        step      = recode_step(bit_here, bit_above, carry_in);
        digit     = step.dig;
        carry_out = step.carry;
    end

endmodule

// File: rtl/bcsd_recoder.sv
module bcsd_recoder
    import bcsd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] mark,
    output logic [WIDTH-1:0] negative,
    output logic             carry_top
);

    // Sign-extended operand: one extra copy of the sign on top.
    logic [WIDTH:0] ext;
    logic [WIDTH:0] chain;
    digit_e         digs [WIDTH];

    assign ext      = {operand[WIDTH-1], operand};
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        bcsd_recode_cell u_cell (
            .bit_here  (ext[i]),
            .bit_above (ext[i+1]),
            .carry_in  (chain[i]),
            .digit     (digs[i]),
            .carry_out (chain[i+1])
        );
        assign mark[i]     = (digs[i] != DIG_ZERO);
        assign negative[i] = (digs[i] == DIG_NEG);
    end

    assign carry_top = chain[WIDTH];

endmodule

// File: rtl/bcsd_packer.sv
module bcsd_packer #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] mark,
    input  logic [WIDTH-1:0] negative,
    output logic [WIDTH:0]   code
);

    // A digit's sign lands on the position just above it, which the
    // canonic form guarantees is a zero digit.
    assign code[0] = mark[0];
    for (genvar i = 1; i < WIDTH; i++) begin : g_slot
        assign code[i] = mark[i] | negative[i-1];
    end
    assign code[WIDTH] = negative[WIDTH-1];

endmodule

// File: rtl/bcsd_digit_count.sv
module bcsd_digit_count #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 4
) (
    input  logic [WIDTH-1:0] mark,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++)
            count = count + CNT_W'(mark[i]);
    end

endmodule

// File: rtl/bcsd_encoder.sv
module bcsd_encoder
    import bcsd_pkg::*;
#(
    parameter  int WIDTH = 16,
    localparam int CNT_W = $clog2(WIDTH / 2 + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] operand,
    output logic             out_valid,
    output logic [WIDTH:0]   code_out,
    output logic [CNT_W-1:0] nz_count
);

    logic [WIDTH-1:0] mark;
    logic [WIDTH-1:0] negative;
    logic             carry_top;
    logic [WIDTH:0]   code_d;
    logic [CNT_W-1:0] count_d;

    bcsd_recoder #(.WIDTH(WIDTH)) u_recoder (
        .operand   (operand),
        .mark      (mark),
        .negative  (negative),
        .carry_top (carry_top)
    );

    bcsd_packer #(.WIDTH(WIDTH)) u_packer (
        .mark     (mark),
        .negative (negative),
        .code     (code_d)
    );

    bcsd_digit_count #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_count (
        .mark  (mark),
        .count (count_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            code_out  <= '0;
            nz_count  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                code_out <= code_d;
                nz_count <= count_d;
            end
        end
    end

    // Checking views of the registered word and the live operand.
    logic [MAX_W:0] code_wide;
    longint         op_value;
    assign code_wide = {{(MAX_W - WIDTH){1'b0}}, code_out};
    assign op_value  = longint'($signed(operand));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && code_out == '0 && nz_count == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(code_out) && $stable(nz_count))); // R3
    AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> packed_value(code_wide, WIDTH) == $past(op_value)); // R4
    AST_NO_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ((mark & (mark >> 1)) == '0)); // R5
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(nz_count) == packed_marks(code_wide, WIDTH)); // R6
    AST_TOP_SIGN: assert property (@(posedge clk) disable iff (rst)
        code_out[WIDTH] |-> code_out[WIDTH-1]); // R7
    AST_CARRY_SIGN: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> carry_top == operand[WIDTH-1]); // R7

endmodule

// File: tb/bcsd_encoder_test.sv
module bcsd_encoder_test;

    localparam int W  = 8;
    localparam int CW = $clog2(W / 2 + 2);
    localparam int NT = 8;

    // Hand-worked vectors: operand, packed word, nonzero count.
    localparam logic [W-1:0]  T_OP   [NT] = '{8'h00, 8'h01, 8'hFF, 8'h7F, 8'h80, 8'h55, 8'h3B, 8'hAB};
    localparam logic [W:0]    T_CODE [NT] = '{9'h000, 9'h001, 9'h003, 9'h083, 9'h180, 9'h055, 9'h04F, 9'h0FF};
    localparam logic [CW-1:0] T_CNT  [NT] = '{3'd0, 3'd1, 3'd1, 3'd2, 3'd1, 3'd4, 3'd3, 3'd4};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  operand = '0;
    logic          out_valid;
    logic [W:0]    code_out;
    logic [CW-1:0] nz_count;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    bcsd_encoder #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .operand   (operand),
        .out_valid (out_valid),
        .code_out  (code_out),
        .nz_count  (nz_count)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Canonic form by remainder-and-halve on the signed value.
    task automatic model(input logic [W-1:0] op, output logic [W:0] code, output int cnt);
        longint v;
        v    = longint'($signed(op));
        code = '0;
        cnt  = 0;
        for (int p = 0; p < W; p++) begin
            if (v[0]) begin
                code[p] = 1'b1;
                cnt++;
                if (v[1:0] == 2'b11) begin
                    code[p+1] = 1'b1;
                    v = v + 1;
                end else begin
                    v = v - 1;
                end
            end
            v = v >>> 1;
        end
    endtask

    function automatic longint read_value(input logic [W:0] c);
        longint acc  = 0;
        logic   skip = 1'b0;
        for (int j = 0; j < W; j++) begin
            if (skip) skip = 1'b0;
            else if (c[j]) begin
                acc  = c[j+1] ? acc - (longint'(1) <<< j) : acc + (longint'(1) <<< j);
                skip = 1'b1;
            end
        end
        return acc;
    endfunction

    task automatic apply(input logic [W-1:0] op);
        @(negedge clk);
        operand  = op;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [W:0] exp_code;
        int         exp_cnt;

        repeat (3) @(negedge clk);
        check("R1 valid", out_valid, 0);
        check("R1 code", code_out, 0);
        check("R1 count", nz_count, 0);
        rst = 1'b0;

        // Table walk.
        for (int k = 0; k < NT; k++) begin
            apply(T_OP[k]);
            check("R7 table code", code_out, T_CODE[k]);
            check("R6 table count", nz_count, T_CNT[k]);
        end

        // Exhaustive sweep against the arithmetic model.
        for (int v = 0; v < (1 << W); v++) begin
            apply(W'(v));
            model(W'(v), exp_code, exp_cnt);
            check("R2 valid high", out_valid, 1);
            check("R5 canonic word", code_out, exp_code);
            check("R4 value", read_value(code_out), longint'($signed(W'(v))));
            check("R6 count", nz_count, exp_cnt);
            check("R7 top sign", (code_out[W] && !code_out[W-1]) ? 1 : 0, 0);
        end

        // Strobe low: result holds, valid drops.
        apply(8'h3B);
        @(negedge clk);
        check("R2 valid low", out_valid, 0);
        operand = 8'hAB;
        repeat (3) @(negedge clk);
        check("R3 hold code", code_out, 9'h04F);
        check("R3 hold count", nz_count, 3);

        // Reset mid-stream clears the held result.
        rst = 1'b1;
        @(negedge clk);
        check("R1 reclear code", code_out, 0);
        check("R1 reclear valid", out_valid, 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule